// File: doc/BRIEF.md
# Sensor Pixel Capture and Packer

This block sits right after a parallel monochrome image sensor. It runs on the sensor's pixel clock. It takes a frame-valid strobe, a line-valid strobe and a 10-bit pixel bus, and emits 16-bit words for a downstream frame buffer. Each accepted pixel is cut down to 8-bit grey. Two grey pixels are paired into one word.

The sensor launches data on the rising edge of its clock, so the block samples its inputs on the falling edge. A small state machine on the rising edge tracks four conditions: no frame, frame open between lines, inside a line, and line gap. In preview mode the block keeps only the even-numbered rows and columns of each frame, which halves both dimensions (a 1280 x 1024 frame becomes 640 x 512). Every output comes from a register, so none of them can glitch. A word strobe, a start-of-frame flag and an end-of-frame pulse go with the data word.

Top module: `pix_capture_pack`

## Requirements
- R1: A pixel is accepted only on a falling-edge sample where both `fv_in` and `lv_in` are high. Pixel-bus values at any other time produce no word.
- R2: Inputs are sampled on the falling edge of `pix_clk`. A word goes out on the first rising edge after the falling edge that sampled the pixel completing it.
- R3: The grey value of a pixel is bits [9:2] of `pix_in`.
- R4: The first accepted pixel of a pair goes in `word_data[7:0]`, and the second goes in `word_data[15:8]`.
- R5: A line that ends with an unpaired accepted pixel gets one extra word. That word holds the pixel in bits [7:0] and zero in bits [15:8], and it is written at line end.
- R6: With `skip_en` high at the start of a frame, only pixels whose row index and column index are both even are accepted. Indices count from 0 at the start of each frame and each line.
- R7: With `skip_en` low, every valid pixel is accepted, giving ceil(N/2) words for a line of N pixels.
- R8: `sof` is high together with the first word of a frame and with no other word.
- R9: `eof` is a single-cycle pulse on the rising edge after the falling edge that first samples `fv_in` low.
- R10: While `rst` is high, and on the rising edge after it, `word_wr`, `sof` and `eof` are low.
- R11: `word_wr` is high for exactly one cycle per word and is never high on two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pix_clk | input | 1 | Sensor pixel clock; the sensor launches data on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| skip_en | input | 1 | Preview mode: keep even rows and even columns only |
| fv_in | input | 1 | Frame-valid strobe from the sensor |
| lv_in | input | 1 | Line-valid strobe from the sensor |
| pix_in | input | 10 | Raw pixel value |
| word_data | output | 16 | Two packed grey pixels |
| word_wr | output | 1 | Write strobe for `word_data` |
| sof | output | 1 | Marks the first word of a frame |
| eof | output | 1 | Pulse after the frame closes |

## Verification
Frames of several sizes are driven, with the pixel value computed from frame, row and column, and with garbage on the pixel bus outside line-valid. Full-resolution frames with even and odd line widths separate plain pairing from the end-of-line flush. Preview frames whose kept-column count is odd and even separate the row/column decimation from the flush path, and also show whether the counters restart on each line and frame. Cycle counts taken from the moment the completing pixel is driven, and from the moment frame-valid falls, pin down falling-edge sampling and the one-register output latency.

// File: rtl/pcap_pkg.sv
package pcap_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_LINE = 2'd2,
    ST_GAP  = 2'd3
  } cap_state_e;
endpackage

// File: rtl/pcap_sample.sv
// Falling-edge input register: the sensor launches on the rising edge.
module pcap_sample #(
  parameter int PIX_W  = 10,
  parameter int GREY_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fv_in,
  input  logic              lv_in,
  input  logic [PIX_W-1:0]  pix_in,
  output logic              s_fv,
  output logic              s_lv,
  output logic [GREY_W-1:0] s_grey
);
  localparam int DROP_W = PIX_W - GREY_W;

  logic [DROP_W-1:0] unused_low;
  assign unused_low = pix_in[DROP_W-1:0];

  always_ff @(negedge clk) begin
    if (rst) begin
      s_fv   <= 1'b0;
      s_lv   <= 1'b0;
      s_grey <= '0;
    end else begin
      s_fv   <= fv_in;
      s_lv   <= lv_in;
      s_grey <= pix_in[PIX_W-1 -: GREY_W];
    end
  end
endmodule

// File: rtl/pcap_track.sv
// Frame/line state machine, row/column counters and decimation decision.
module pcap_track
  import pcap_pkg::*;
#(
  parameter int COLS = 1280,
  parameter int ROWS = 1024
) (
  input  logic clk,
  input  logic rst,
  input  logic skip_en,
  input  logic s_fv,
  input  logic s_lv,
  output logic keep,
  output logic line_end,
  output logic frame_start,
  output logic frame_end
);
  localparam int CW = $clog2(COLS + 1);
  localparam int RW = $clog2(ROWS + 1);

  cap_state_e    state, state_nx;
  logic [CW-1:0] col_cnt;
  logic [RW-1:0] row_cnt;
  logic          skip_q;
  logic          skip_eff;
  logic          pix_ok;

  assign pix_ok      = s_fv && s_lv;
  assign skip_eff    = (state == ST_IDLE) ? skip_en : skip_q;
  assign frame_start = (state == ST_IDLE) && s_fv;
  assign frame_end   = (state != ST_IDLE) && !s_fv;
  assign line_end    = (state == ST_LINE) && !pix_ok;
  assign keep        = pix_ok && (!skip_eff || (!col_cnt[0] && !row_cnt[0]));

  always_comb begin
    state_nx = state;
    case (state)
      ST_IDLE: if (s_fv) state_nx = s_lv ? ST_LINE : ST_WAIT;
      ST_WAIT,
      ST_GAP:  if (!s_fv) state_nx = ST_IDLE;
               else if (s_lv) state_nx = ST_LINE;
      ST_LINE: if (!s_fv) state_nx = ST_IDLE;
               else if (!s_lv) state_nx = ST_GAP;
      default: state_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      col_cnt <= '0;
      row_cnt <= '0;
      skip_q  <= 1'b0;
    end else begin
      state <= state_nx;
      if (state == ST_IDLE) skip_q <= skip_en;
      if (pix_ok) col_cnt <= col_cnt + CW'(1);
      else        col_cnt <= '0;
      if (!s_fv)         row_cnt <= '0;
      else if (line_end) row_cnt <= row_cnt + RW'(1);
    end
  end

  // R1: being inside a line implies both strobes were seen high
  a_r1_line_state: assert property (@(posedge clk) disable iff (rst)
    (state == ST_LINE) |-> $past(s_fv && s_lv));

  // R6: column index advances by one per valid pixel
  a_r6_col_step: assert property (@(posedge clk) disable iff (rst)
    (s_fv && s_lv) |=> (col_cnt == $past(col_cnt) + CW'(1)));

  // R6: column index restarts between lines
  a_r6_col_restart: assert property (@(posedge clk) disable iff (rst)
    (state == ST_GAP) |-> (col_cnt == '0));
endmodule

// File: rtl/pcap_pack.sv
// Pairs grey pixels into words, flushes odd tails, tags frame boundaries.
module pcap_pack #(
  parameter int GREY_W = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                keep,
  input  logic                line_end,
  input  logic                frame_start,
  input  logic                frame_end,
  input  logic [GREY_W-1:0]   s_grey,
  output logic [2*GREY_W-1:0] word_data,
  output logic                word_wr,
  output logic                sof,
  output logic                eof
);
  logic [GREY_W-1:0] low_byte;
  logic              half;
  logic              sof_pend;

  always_ff @(posedge clk) begin
    if (rst) begin
      word_data <= '0;
      word_wr   <= 1'b0;
      sof       <= 1'b0;
      eof       <= 1'b0;
      low_byte  <= '0;
      half      <= 1'b0;
      sof_pend  <= 1'b0;
    end else begin
      word_wr <= 1'b0;
      sof     <= 1'b0;
      eof     <= frame_end;
      if (keep) begin
        if (!half) begin
          low_byte <= s_grey;
          half     <= 1'b1;
        end else begin
          word_data <= {s_grey, low_byte};
          word_wr   <= 1'b1;
          sof       <= sof_pend;
          sof_pend  <= 1'b0;
          half      <= 1'b0;
        end
      end else if (line_end && half) begin
        word_data <= {{GREY_W{1'b0}}, low_byte};
        word_wr   <= 1'b1;
        sof       <= sof_pend;
        sof_pend  <= 1'b0;
        half      <= 1'b0;
      end
      if (frame_start)    sof_pend <= 1'b1;
      else if (frame_end) sof_pend <= 1'b0;
    end
  end

  // R8: the frame tag only rides on a written word
  a_r8_sof_with_wr: assert property (@(posedge clk) disable iff (rst)
    sof |-> word_wr);

  // R9: end-of-frame lasts a single cycle
  a_r9_eof_single: assert property (@(posedge clk) disable iff (rst)
    eof |=> !eof);

  // R11: a word needs an accepted pixel or a line end one cycle earlier
  a_r11_wr_cause: assert property (@(posedge clk) disable iff (rst)
    word_wr |-> $past(keep || line_end));

  // R11: strobes never back to back
  a_r11_no_back_to_back: assert property (@(posedge clk) disable iff (rst)
    word_wr |=> !word_wr);

  // R5: flush word carries zero in its upper byte
  a_r5_flush_zero: assert property (@(posedge clk) disable iff (rst)
    (word_wr && $past(line_end)) |-> (word_data[2*GREY_W-1:GREY_W] == '0));
endmodule

// File: rtl/pix_capture_pack.sv
module pix_capture_pack #(
  parameter int PIX_W  = 10,
  parameter int GREY_W = 8,
  parameter int COLS   = 1280,
  parameter int ROWS   = 1024
) (
  input  logic                pix_clk,
  input  logic                rst,
  input  logic                skip_en,
  input  logic                fv_in,
  input  logic                lv_in,
  input  logic [PIX_W-1:0]    pix_in,
  output logic [2*GREY_W-1:0] word_data,
  output logic                word_wr,
  output logic                sof,
  output logic                eof
);
  logic              s_fv, s_lv;
  logic [GREY_W-1:0] s_grey;
  logic              keep, line_end, frame_start, frame_end;

  pcap_sample #(.PIX_W(PIX_W), .GREY_W(GREY_W)) u_sample (
    .clk(pix_clk), .rst(rst), .fv_in(fv_in), .lv_in(lv_in), .pix_in(pix_in),
    .s_fv(s_fv), .s_lv(s_lv), .s_grey(s_grey)
  );

  pcap_track #(.COLS(COLS), .ROWS(ROWS)) u_track (
    .clk(pix_clk), .rst(rst), .skip_en(skip_en), .s_fv(s_fv), .s_lv(s_lv),
    .keep(keep), .line_end(line_end), .frame_start(frame_start),
    .frame_end(frame_end)
  );

  pcap_pack #(.GREY_W(GREY_W)) u_pack (
    .clk(pix_clk), .rst(rst), .keep(keep), .line_end(line_end),
    .frame_start(frame_start), .frame_end(frame_end), .s_grey(s_grey),
    .word_data(word_data), .word_wr(word_wr), .sof(sof), .eof(eof)
  );

  // R10: reset leaves all strobes low on the following edge
  a_r10_reset_quiet: assert property (@(posedge pix_clk)
    rst |=> (!word_wr && !sof && !eof));
endmodule

// File: tb/test_pix_capture_pack.sv
module test_pix_capture_pack;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        skip_en = 1'b0;
  logic        fv_in = 1'b0;
  logic        lv_in = 1'b0;
  logic [9:0]  pix_in = '0;
  logic [15:0] word_data;
  logic        word_wr, sof, eof;

  pix_capture_pack #(.PIX_W(10), .GREY_W(8), .COLS(16), .ROWS(8)) i_pix_capture_pack (
    .pix_clk(clk), .rst(rst), .skip_en(skip_en), .fv_in(fv_in), .lv_in(lv_in),
    .pix_in(pix_in), .word_data(word_data), .word_wr(word_wr), .sof(sof), .eof(eof)
  );

  always #10 clk = ~clk;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  logic [15:0] got_w [0:255];
  bit          got_sof [0:255];
  int got_n = 0, eof_n = 0, eof_cyc = 0, first_wr_cyc = 0, consec = 0;
  bit prev_wr = 0;

  always @(negedge clk) begin
    if (!rst) begin
      if (word_wr) begin
        if (got_n == 0) first_wr_cyc = cyc;
        if (got_n < 256) begin
          got_w[got_n]   = word_data;
          got_sof[got_n] = sof;
        end
        got_n++;
        if (prev_wr) consec++;
      end
      if (eof) begin
        eof_n++;
        eof_cyc = cyc;
      end
      prev_wr = word_wr;
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [9:0] pixval(int f, int r, int c);
    return 10'((f * 97 + r * 41 + c * 13 + 5) % 1024);
  endfunction

  task automatic run_frame(input int f, input int cols, input int rows, input bit skip);
    logic [15:0] exp_w [0:255];
    int en = 0, n2_cyc = 0, fall_cyc = 0, sof_sum = 0, first_line_words = 0;
    bit have;
    logic [7:0] lo;
    got_n = 0; eof_n = 0; consec = 0;
    @(posedge clk); #2;
    skip_en = skip; fv_in = 1'b1; lv_in = 1'b0; pix_in = 10'h3A5;
    @(posedge clk); #2;
    @(posedge clk); #2;
    for (int r = 0; r < rows; r++) begin
      for (int c = 0; c < cols; c++) begin
        lv_in  = 1'b1;
        pix_in = pixval(f, r, c);
        if (r == 0 && c == (skip ? 2 : 1)) n2_cyc = cyc;
        @(posedge clk); #2;
      end
      lv_in = 1'b0;
      for (int g = 0; g < 3; g++) begin
        pix_in = 10'(10'h2C3 ^ (g * 77 + r));
        @(posedge clk); #2;
      end
    end
    fv_in = 1'b0; fall_cyc = cyc;
    for (int g = 0; g < 4; g++) begin
      pix_in = 10'(10'h155 + g);
      @(posedge clk); #2;
    end
    for (int r = 0; r < rows; r++) begin
      if (skip && (r % 2) != 0) continue;
      have = 0;
      for (int c = 0; c < cols; c++) begin
        if (skip && (c % 2) != 0) continue;
        if (!have) begin
          lo = pixval(f, r, c)[9:2];
          have = 1;
        end else begin
          exp_w[en] = {pixval(f, r, c)[9:2], lo};
          en++;
          have = 0;
        end
      end
      if (have) begin
        exp_w[en] = {8'h00, lo};
        en++;
      end
      if (r == 0) first_line_words = en;
    end
    // R1 R6 R7: word count reflects accepted pixels only
    check(got_n == en, skip ? "R1/R6 word count" : "R1/R7 word count", got_n, en);
    for (int i = 0; i < en && i < got_n; i++)
      check(got_w[i] == exp_w[i], "R4 word content", got_w[i], exp_w[i]);
    // R3: low byte of first word is top bits of first pixel
    check(got_w[0][7:0] == pixval(f, 0, 0)[9:2], "R3 grey truncation",
          got_w[0][7:0], pixval(f, 0, 0)[9:2]);
    // R5: odd tail on the first line
    if (((skip ? (cols + 1) / 2 : cols) % 2) == 1)
      check(got_w[first_line_words-1][15:8] == 8'h00, "R5 flush upper byte",
            got_w[first_line_words-1][15:8], 0);
    for (int i = 0; i < got_n && i < 256; i++) sof_sum += got_sof[i];
    check(got_sof[0] == 1'b1 && sof_sum == 1, "R8 sof placement", sof_sum, 1);
    check(eof_n == 1, "R9 eof count", eof_n, 1);
    check(eof_cyc == fall_cyc + 1, "R9 eof timing", eof_cyc, fall_cyc + 1);
    check(first_wr_cyc == n2_cyc + 1, "R2 falling-edge latency", first_wr_cyc, n2_cyc + 1);
    check(consec == 0, "R11 single-cycle strobe", consec, 0);
  endtask

  initial begin
    #(20 * 100000);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(!word_wr && !sof && !eof, "R10 outputs in reset",
          {word_wr, sof, eof}, 0);
    @(posedge clk); #2;
    rst = 1'b0;
    @(negedge clk);
    check(!word_wr && !sof && !eof, "R10 outputs after reset",
          {word_wr, sof, eof}, 0);
    run_frame(0, 6, 4, 1'b0);
    run_frame(1, 5, 3, 1'b0);
    run_frame(2, 6, 4, 1'b1);
    run_frame(3, 8, 5, 1'b1);
    run_frame(4, 7, 3, 1'b1);
    run_frame(5, 16, 8, 1'b0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule